// File: doc/BRIEF.md
# Tone Guard-Time Steering Controller

This block sits behind a tone detector and decides which of its raw "tone present" indications count as real digits. The detector supplies an early-steering level and a 4-bit decoded digit. The controller holds off until early steering has stayed high for a programmable number of clock samples (the present guard). It then captures the digit into an output register and raises a delayed-steering flag one cycle later. The flag is dropped only after early steering has stayed low for a second, independently programmed number of samples (the absent guard). Short bursts are discarded and short dropouts are bridged. In each case neither the flag nor the captured digit changes.

Both guards are cycle counters with 16-bit load values, in place of a resistor-capacitor network. A guard load of 0 behaves like a load of 1. The smallest tone that is recognised lasts the detector's own present delay plus the present guard. The smallest pause that is recognised lasts the detector's absent delay plus the absent guard. The code register always updates. An output-enable input only produces a drive-enable for the code pads, so the flag and the stored digit are unaffected when the pads are released.

The controller is a five-state machine:
- IDLE: no tone, flag low.
- ON_QUAL: early steering is high and the present guard is running.
- LOAD: the digit has just been captured and the flag has not yet risen.
- ACTIVE: tone accepted, flag high.
- OFF_QUAL: early steering is low and the absent guard is running, flag still high.

The transitions are:
- IDLE to ON_QUAL when steering rises and the present guard is 2 or more.
- IDLE to LOAD when steering rises and the present guard is 0 or 1.
- ON_QUAL to LOAD when the present guard is reached.
- ON_QUAL to IDLE when steering falls early.
- LOAD to ACTIVE always.
- ACTIVE to OFF_QUAL when steering falls and the absent guard is 2 or more.
- ACTIVE to IDLE when steering falls and the absent guard is 0 or 1.
- OFF_QUAL to IDLE when the absent guard is reached.
- OFF_QUAL to ACTIVE when steering rises early.

Top module: `tone_steer_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves the block in IDLE with dly_steer_o = 0 and code_o = 4'h0.
- R2: A run of high early_steer_i samples shorter than the present guard leaves dly_steer_o and code_o unchanged.
- R3: When early_steer_i has been sampled high at Gp consecutive rising edges, code_o takes the value of digit_i sampled at that Gp-th edge. Gp = max(guard_on_i, 1). This is the only event that changes code_o, apart from reset.
- R4: dly_steer_o rises exactly one clock edge after the edge at which code_o was loaded.
- R5: While the flag is high, a run of low samples shorter than the absent guard leaves dly_steer_o and code_o unchanged.
- R6: While the flag is high, the flag falls at the edge that completes Ap consecutive low samples of early_steer_i, where Ap = max(guard_off_i, 1). code_o keeps its value when the flag falls.
- R7: The present and absent guards act independently, and each works for every load value, including 0 and 1.
- R8: code_oe_o equals oe_i at all times. Holding oe_i low does not stop code_o from loading or dly_steer_o from rising.
- R9: A level change of early_steer_i before a guard expires restarts that guard. A tone needs Gp high samples in one unbroken run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| early_steer_i | input | 1 | Raw tone-present level from the detector |
| digit_i | input | 4 | Decoded digit from the detector |
| guard_on_i | input | 16 | Present guard in clock cycles |
| guard_off_i | input | 16 | Absent guard in clock cycles |
| oe_i | input | 1 | Output enable for the code pads |
| dly_steer_o | output | 1 | Qualified tone flag |
| code_o | output | 4 | Captured digit |
| code_oe_o | output | 1 | Drive-enable for the code pads (pads are high impedance when low) |

## Verification
The bench sweeps every combination of present guards 0, 1, 2, 3 and 5 with absent guards 0, 1, 2 and 4. Pseudo-random run lengths are chosen to fall on both sides of each guard, so off-by-one errors at the guard boundary appear as a flag one cycle early or late. Directed sequences cover the remaining cases:
- A burst one sample short of the guard: a design that counts it would load a new digit.
- A dropout inside a tone: a design that does not bridge it would drop the flag.
- A broken run whose pieces add up to the guard: a counter that does not restart would accept it.
- A tone accepted with the pads disabled: a design gated by the enable would keep the old digit.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ON_QUAL  = 3'd1,
        ST_LOAD     = 3'd2,
        ST_ACTIVE   = 3'd3,
        ST_OFF_QUAL = 3'd4
    } steer_state_t;
endpackage

// File: rtl/tsc_guard_timer.sv
module tsc_guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] guard,
    output logic             short_guard,
    output logic             hit
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_cnt;

    // samples seen so far in the current run; entry into the run already counts one
    assign next_cnt    = {1'b0, cnt_q} + EXT_W'(1);
    assign short_guard = (guard <= CNT_W'(1));
    assign hit         = run && (next_cnt >= {1'b0, guard});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= CNT_W'(1);
        end else begin
            cnt_q <= next_cnt[CNT_W-1:0];
        end
    end

    // R9
    restart_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic est,
    input  logic on_short,
    input  logic on_hit,
    input  logic off_short,
    input  logic off_hit,
    output logic on_run,
    output logic off_run,
    output logic load_en,
    output logic flag
);
    steer_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (est) begin
                    if (on_short) begin
                        state_d = ST_LOAD;
                        load_en = 1'b1;
                    end else begin
                        state_d = ST_ON_QUAL;
                    end
                end
            end
            ST_ON_QUAL: begin
                if (!est) begin
                    state_d = ST_IDLE;
                end else if (on_hit) begin
                    state_d = ST_LOAD;
                    load_en = 1'b1;
                end
            end
            ST_LOAD: begin
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!est) begin
                    state_d = off_short ? ST_IDLE : ST_OFF_QUAL;
                end
            end
            ST_OFF_QUAL: begin
                if (est) begin
                    state_d = ST_ACTIVE;
                end else if (off_hit) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        on_run  = (state_q == ST_ON_QUAL);
        off_run = (state_q == ST_OFF_QUAL);
        flag    = (state_q == ST_ACTIVE) || (state_q == ST_OFF_QUAL);
    end

    // R4
    flag_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (!flag ##1 flag));

    // R9
    on_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (on_run && !est) |=> (state_q == ST_IDLE));

    // R5
    off_bridge_chk: assert property (@(posedge clk) disable iff (rst)
        (off_run && est) |=> flag);
endmodule

// File: rtl/tsc_code_latch.sv
module tsc_code_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [CODE_W-1:0] digit,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (load_en) begin
            code <= digit;
        end
    end

    // R3
    load_only_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(code));
endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl #(
    parameter int CODE_W  = 4,
    parameter int GUARD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               early_steer_i,
    input  logic [CODE_W-1:0]  digit_i,
    input  logic [GUARD_W-1:0] guard_on_i,
    input  logic [GUARD_W-1:0] guard_off_i,
    input  logic               oe_i,
    output logic               dly_steer_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               code_oe_o
);
    logic on_run, off_run, on_short, off_short, on_hit, off_hit, load_en;

    tsc_guard_timer #(.CNT_W(GUARD_W)) u_on_timer (
        .clk(clk), .rst(rst), .run(on_run), .guard(guard_on_i),
        .short_guard(on_short), .hit(on_hit)
    );

    tsc_guard_timer #(.CNT_W(GUARD_W)) u_off_timer (
        .clk(clk), .rst(rst), .run(off_run), .guard(guard_off_i),
        .short_guard(off_short), .hit(off_hit)
    );

    tsc_fsm u_fsm (
        .clk(clk), .rst(rst), .est(early_steer_i),
        .on_short(on_short), .on_hit(on_hit),
        .off_short(off_short), .off_hit(off_hit),
        .on_run(on_run), .off_run(off_run),
        .load_en(load_en), .flag(dly_steer_o)
    );

    tsc_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk(clk), .rst(rst), .load_en(load_en),
        .digit(digit_i), .code(code_o)
    );

    assign code_oe_o = oe_i;

    // R6
    code_hold_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dly_steer_o) |-> $stable(code_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!dly_steer_o && (code_o == '0)));
endmodule

// File: tb/test_tone_steer_ctrl.sv
module test_tone_steer_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        est = 1'b0;
    logic [3:0]  digit = 4'h0;
    logic [15:0] g_on = 16'd3;
    logic [15:0] g_off = 16'd2;
    logic        oe = 1'b1;
    logic        flag;
    logic [3:0]  code;
    logic        code_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tone_steer_ctrl i_tone_steer_ctrl (
        .clk(clk), .rst(rst), .early_steer_i(est), .digit_i(digit),
        .guard_on_i(g_on), .guard_off_i(g_off), .oe_i(oe),
        .dly_steer_o(flag), .code_o(code), .code_oe_o(code_oe)
    );

    // reference model: run lengths of sampled levels
    int         m_mode = 0;
    int         m_hi = 0;
    int         m_lo = 0;
    logic       e_flag = 1'b0;
    logic [3:0] e_code = 4'h0;

    function automatic int eff(input logic [15:0] g);
        return (g == 16'd0) ? 1 : int'(g);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_hi = 0; m_lo = 0; e_flag = 1'b0; e_code = 4'h0;
        end else begin
            case (m_mode)
                0: begin
                    m_hi = est ? m_hi + 1 : 0;
                    if (m_hi >= eff(g_on)) begin
                        e_code = digit; m_mode = 1; m_hi = 0;
                    end
                end
                1: begin
                    e_flag = 1'b1; m_mode = 2; m_lo = 0;
                end
                default: begin
                    m_lo = est ? 0 : m_lo + 1;
                    if (m_lo >= eff(g_off)) begin
                        e_flag = 1'b0; m_mode = 0; m_hi = 0;
                    end
                end
            endcase
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R3 code", int'(code), int'(e_code));
            check(e_flag ? "R4 flag" : "R6 flag", int'(flag), int'(e_flag));
            check("R8 oe", int'(code_oe), int'(oe));
        end
    end

    task automatic step(input logic s, input logic [3:0] d);
        est = s; digit = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; est = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 flag", int'(flag), 0);
        check("R1 code", int'(code), 0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // directed: present 3, absent 2
        g_on = 16'd3; g_off = 16'd2;
        do_reset();
        model_on = 1'b1;
        // accept digit 5
        step(1, 4'h5); step(1, 4'h5); step(1, 4'h5);
        check("R3 load", int'(code), 5);
        check("R4 not yet", int'(flag), 0);
        step(1, 4'h5);
        check("R4 rise", int'(flag), 1);
        // dropout of one sample bridged
        step(0, 4'h0); step(1, 4'h0);
        check("R5 flag", int'(flag), 1);
        check("R5 code", int'(code), 5);
        // end of tone
        step(0, 4'h0); step(0, 4'h0);
        check("R6 fall", int'(flag), 0);
        check("R6 hold", int'(code), 5);
        // short burst of 2 ignored
        step(1, 4'h9); step(1, 4'h9); step(0, 4'h9); step(0, 4'h9);
        check("R2 flag", int'(flag), 0);
        check("R2 code", int'(code), 5);
        // broken run 2+2 rejected, third sample of second run accepts
        step(1, 4'hA); step(1, 4'hA); step(0, 4'hA);
        step(1, 4'hC); step(1, 4'hC);
        check("R9 restart", int'(code), 5);
        step(1, 4'hC);
        check("R9 accept", int'(code), 12);
        step(1, 4'hC);
        step(0, 4'h0); step(0, 4'h0);
        // tone accepted with pads disabled
        oe = 1'b0;
        step(1, 4'h7); step(1, 4'h7); step(1, 4'h7); step(1, 4'h7);
        check("R8 code", int'(code), 7);
        check("R8 flag", int'(flag), 1);
        check("R8 oe", int'(code_oe), 0);
        step(0, 4'h0); step(0, 4'h0);
        oe = 1'b1;

        // sweep of guard pairs with pseudo-random run lengths
        begin
            logic [15:0] lfsr = 16'hACE1;
            int ons[5] = '{0, 1, 2, 3, 5};
            int offs[4] = '{0, 1, 2, 4};
            for (int a = 0; a < 5; a++) begin
                for (int b = 0; b < 4; b++) begin
                    model_on = 1'b0;
                    g_on = 16'(ons[a]); g_off = 16'(offs[b]);
                    do_reset();
                    model_on = 1'b1;
                    for (int r = 0; r < 60; r++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        for (int k = 0; k <= int'(lfsr[2:0]); k++) begin
                            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                            oe = lfsr[5];
                            // R7 guard pair sweep
                            step(logic'(r % 2), lfsr[11:8]);
                        end
                    end
                end
            end
        end
        model_on = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run incomplete)");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule